// File: doc/BRIEF.md
# Byte-Wide Microsequencer Execution Core

This block is a small 8-bit sequencing engine. It executes 32-bit instruction words held in an internal program store, one instruction per clock while the run input is high. Its operands live in a 256-entry byte register space. Two of those registers have fixed roles: an accumulator at address 0x01 and a source-index register at address 0x02. The instruction set covers bitwise logic, addition with and without carry-in, plain and carry-conditional jumps, subroutine calls with a small return stack, and branches that compare or test a register against an operand. Any non-jump instruction can also return from a subroutine.

Software, or a neighbouring controller, loads the program through a write-only load port. It presets and inspects registers through a debug port, then raises run. When the core meets an instruction it does not execute, it stops with a sticky error flag. The flag clears only on reset. The program counter is visible at all times. Shift and rotate instructions are decoded elsewhere and are trapped here.

Top module: `seqcore_top`

## Requirements
- R1: After reset, pc is 0, carry is 0, illegal is 0, and every register in the byte register space reads 0.
- R2: An instruction with any of bits 31-29 set, or with an opcode of 0101, 0110 or 0111, is not executed. It writes no register, pc holds, and illegal goes high on the next edge and stays high until reset.
- R3: The operand is bits 7-0 of the instruction. When that field is 0, the value of the accumulator (register 0x01) is used as the operand instead.
- R4: Opcodes 0000 (OR), 0001 (AND) and 0010 (XOR) write the source register (address in bits 15-8) combined with the operand into the destination register (bits 23-16). They leave carry unchanged, and pc advances by one.
- R5: Opcode 0011 (ADD) writes source plus operand, and opcode 0100 (ADC) writes source plus operand plus carry. Both write the low 8 bits to the destination and set carry to the ninth bit.
- R6: Opcodes 1000 (always), 1001 (if carry), 1010 (if not carry) and 1011 (always, as a call) jump to the 9-bit address in bits 24-16. A branch not taken goes to pc+1. Each of them writes source OR operand into the source-index register (0x02).
- R7: Opcodes 1100 (branch if source differs from operand), 1101 (branch if source AND operand is nonzero), 1110 (branch if equal) and 1111 (branch if source AND operand is zero) branch to bits 24-16 and write no register.
- R8: A call pushes pc+1 onto a 4-entry return stack. A non-jump instruction with bit 24 set continues at the most recently pushed address and pops it. Nested calls return in last-in, first-out order.
- R9: A debug write takes effect only while run is low. dbg_rdata always shows the register addressed by dbg_addr, with no clock delay.
- R10: While run is low, pc, carry and the registers written by the core all hold. With run high, exactly one instruction executes per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute one instruction per edge while high |
| pl_we | input | 1 | Program store write strobe |
| pl_addr | input | 9 | Program store write address |
| pl_data | input | 32 | Instruction word to store |
| dbg_we | input | 1 | Register write strobe (accepted only with run low) |
| dbg_addr | input | 8 | Register address for debug read and write |
| dbg_wdata | input | 8 | Register write data |
| dbg_rdata | output | 8 | Register read data, combinational |
| pc | output | 9 | Program counter |
| carry | output | 1 | Carry flag |
| illegal | output | 1 | Sticky unexecutable-instruction flag |

## Verification
An instruction fetched in one cycle shows all of its results one edge later: the destination or source-index register, carry, pc, the return stack, and the illegal flag for a trapped word. A debug read is visible in the same cycle as its address. The bench drives and samples on the falling clock edge. It runs each program until illegal rises on a deliberate trap word, then drops run before it reads registers, so every result is read after it has settled and cannot be disturbed. For the one-instruction step check, run is held high across exactly one rising edge, and pc and the destination are sampled at the next falling edge.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int DW = 8;
    localparam int IW = 32;

    typedef enum logic [3:0] {
        OP_OR   = 4'h0,
        OP_AND  = 4'h1,
        OP_XOR  = 4'h2,
        OP_ADD  = 4'h3,
        OP_ADC  = 4'h4,
        OP_SHF  = 4'h5,
        OP_RS6  = 4'h6,
        OP_RS7  = 4'h7,
        OP_JMP  = 4'h8,
        OP_JC   = 4'h9,
        OP_JNC  = 4'hA,
        OP_CALL = 4'hB,
        OP_JNE  = 4'hC,
        OP_JNZ  = 4'hD,
        OP_JE   = 4'hE,
        OP_JZ   = 4'hF
    } op_e;
endpackage

// File: rtl/seq_progmem.sv
module seq_progmem #(
    parameter int AW = 9,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [IW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [7:0]  ACC_ADDR = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    output logic [DW-1:0] acc_data
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign ra_data  = regs_q[ra_addr];
    assign rb_data  = regs_q[rb_addr];
    assign acc_data = regs_q[ACC_ADDR[AW-1:0]];
endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (op == OP_ADC) & cin};
        cout = sum[W];
        case (op)
            OP_AND:         res = a & b;
            OP_XOR:         res = a ^ b;
            OP_ADD, OP_ADC: res = sum[W-1:0];
            default:        res = a | b;
        endcase
    end
endmodule

// File: rtl/seqcore_top.sv
module seqcore_top
    import seq_pkg::*;
#(
    parameter int         PC_W       = 9,
    parameter int         RA_W       = 8,
    parameter int         STK_DEPTH  = 4,
    parameter logic [7:0] ACC_ADDR   = 8'h01,
    parameter logic [7:0] SIDX_ADDR  = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            pl_we,
    input  logic [PC_W-1:0] pl_addr,
    input  logic [IW-1:0]   pl_data,
    input  logic            dbg_we,
    input  logic [RA_W-1:0] dbg_addr,
    input  logic [DW-1:0]   dbg_wdata,
    output logic [DW-1:0]   dbg_rdata,
    output logic [PC_W-1:0] pc,
    output logic            carry,
    output logic            illegal
);
    typedef struct packed {
        logic [PC_W-1:0]                 pc;
        logic                            carry;
        logic                            illegal;
        logic [STK_DEPTH-1:0][PC_W-1:0]  stk;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [IW-1:0]   instr;
    op_e             op;
    logic [DW-1:0]   src_val, acc_val, operand, alu_res;
    logic            alu_cout;
    op_e             alu_op;
    logic [PC_W-1:0] pc_inc;
    logic            active, legal, taken;
    logic            core_we;
    logic [RA_W-1:0] core_waddr;
    logic            rf_we;
    logic [RA_W-1:0] rf_waddr;
    logic [DW-1:0]   rf_wdata;

    seq_progmem #(.AW(PC_W), .IW(IW)) i_pmem (
        .clk   (clk),
        .we    (pl_we),
        .waddr (pl_addr),
        .wdata (pl_data),
        .raddr (st_q.pc),
        .rdata (instr)
    );

    seq_regfile #(.AW(RA_W), .DW(DW), .ACC_ADDR(ACC_ADDR)) i_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .ra_addr  (instr[15:8]),
        .ra_data  (src_val),
        .rb_addr  (dbg_addr),
        .rb_data  (dbg_rdata),
        .acc_data (acc_val)
    );

    assign op      = op_e'(instr[28:25]);
    assign operand = (instr[7:0] == '0) ? acc_val : instr[7:0];
    assign alu_op  = (instr[28]) ? OP_OR : op;

    seq_alu #(.W(DW)) i_alu (
        .op   (alu_op),
        .a    (src_val),
        .b    (operand),
        .cin  (st_q.carry),
        .res  (alu_res),
        .cout (alu_cout)
    );

    always_comb begin
        st_d       = st_q;
        pc_inc     = st_q.pc + 1'b1;
        active     = run && !st_q.illegal;
        legal      = (instr[31:29] == 3'b000) && !(op inside {OP_SHF, OP_RS6, OP_RS7});
        taken      = 1'b0;
        core_we    = 1'b0;
        core_waddr = instr[23:16];

        if (active) begin
            if (!legal) begin
                st_d.illegal = 1'b1;
            end else if (!instr[28]) begin
                core_we = 1'b1;
                st_d.pc = pc_inc;
                if (op inside {OP_ADD, OP_ADC}) st_d.carry = alu_cout;
                if (instr[24]) begin
                    st_d.pc = st_q.stk[0];
                    for (int i = 0; i < STK_DEPTH - 1; i++) st_d.stk[i] = st_q.stk[i+1];
                    st_d.stk[STK_DEPTH-1] = '0;
                end
            end else if (!instr[27]) begin
                core_we    = 1'b1;
                core_waddr = SIDX_ADDR[RA_W-1:0];
                case (op)
                    OP_JC:   taken = st_q.carry;
                    OP_JNC:  taken = !st_q.carry;
                    default: taken = 1'b1;
                endcase
                st_d.pc = taken ? instr[24:16] : pc_inc;
                if (op == OP_CALL) begin
                    for (int i = STK_DEPTH - 1; i > 0; i--) st_d.stk[i] = st_q.stk[i-1];
                    st_d.stk[0] = pc_inc;
                end
            end else begin
                case (op)
                    OP_JNE:  taken = (src_val != operand);
                    OP_JE:   taken = (src_val == operand);
                    OP_JNZ:  taken = ((src_val & operand) != '0);
                    default: taken = ((src_val & operand) == '0);
                endcase
                st_d.pc = taken ? instr[24:16] : pc_inc;
            end
        end

        rf_we    = core_we || (dbg_we && !run);
        rf_waddr = core_we ? core_waddr : dbg_addr;
        rf_wdata = core_we ? alu_res : dbg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc      = st_q.pc;
    assign carry   = st_q.carry;
    assign illegal = st_q.illegal;

    p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.illegal |=> st_q.illegal);

    p_hold_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || st_q.illegal) |=> $stable(st_q.pc) && $stable(st_q.carry));

    p_logic_keeps_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && legal && (op inside {OP_OR, OP_AND, OP_XOR})) |=> $stable(st_q.carry));

    p_call_pushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && legal && op == OP_CALL)
        |=> (st_q.pc == $past(instr[24:16])) && (st_q.stk[0] == $past(pc_inc)));

    p_return_pops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && legal && !instr[28] && instr[24]) |=> st_q.pc == $past(st_q.stk[0]));
endmodule

// File: tb/test_seqcore_top.sv
module test_seqcore_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        pl_we = 1'b0;
    logic [8:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;
    logic        dbg_we = 1'b0;
    logic [7:0]  dbg_addr = '0;
    logic [7:0]  dbg_wdata = '0;
    logic [7:0]  dbg_rdata;
    logic [8:0]  pc;
    logic        carry;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seqcore_top i_seqcore_top (
        .clk(clk), .rst_n(rst_n), .run(run),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .pc(pc), .carry(carry), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [8:0] d,
                                       input logic [7:0] s, input logic [7:0] imm);
        return {3'b000, op, d, s, imm};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
        dbg_addr = a;
        #1;
        check(req, {24'h0, dbg_rdata}, {24'h0, exp});
    endtask

    task automatic do_reset();
        run = 1'b0; pl_we = 1'b0; dbg_we = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ld(input logic [8:0] a, input logic [31:0] ins);
        pl_we = 1'b1; pl_addr = a; pl_data = ins;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = v;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic run_to_halt(input string req);
        int n;
        n = 0;
        run = 1'b1;
        while (!illegal && n < 100) begin
            @(negedge clk);
            n++;
        end
        run = 1'b0;
        @(negedge clk);
        check(req, {31'h0, illegal}, 32'h1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc", {23'h0, pc}, 32'h0);
        check("R1 carry", {31'h0, carry}, 32'h0);
        check("R1 illegal", {31'h0, illegal}, 32'h0);
        check_reg("R1 reg10", 8'h10, 8'h00);
        check_reg("R1 acc", 8'h01, 8'h00);
    endtask

    task automatic t_logic();
        do_reset();
        wr(8'h10, 8'hF0);
        wr(8'h01, 8'h3C);
        ld(9'd0, mk(4'h0, 9'h020, 8'h10, 8'h0F));
        ld(9'd1, mk(4'h1, 9'h021, 8'h10, 8'h00));
        ld(9'd2, mk(4'h2, 9'h022, 8'h10, 8'hFF));
        ld(9'd3, mk(4'h7, 9'h000, 8'h00, 8'h00));
        run_to_halt("R2 trap op 0111");
        check("R2 pc holds at trap", {23'h0, pc}, 32'd3);
        check_reg("R4 OR", 8'h20, 8'hFF);
        check_reg("R3 AND with acc operand", 8'h21, 8'h30);
        check_reg("R4 XOR", 8'h22, 8'h0F);
        check("R4 carry untouched", {31'h0, carry}, 32'h0);
    endtask

    task automatic t_arith_jumps();
        do_reset();
        wr(8'h10, 8'hC8);
        ld(9'd0, mk(4'h3, 9'h020, 8'h10, 8'h50));
        ld(9'd1, mk(4'h2, 9'h023, 8'h10, 8'h01));
        ld(9'd2, mk(4'h9, 9'd4, 8'h10, 8'h01));
        ld(9'd3, mk(4'h6, 9'h000, 8'h00, 8'h00));
        ld(9'd4, mk(4'h4, 9'h021, 8'h10, 8'h01));
        ld(9'd5, mk(4'hA, 9'd7, 8'h30, 8'h05));
        ld(9'd6, mk(4'h6, 9'h000, 8'h00, 8'h00));
        ld(9'd7, mk(4'h5, 9'h000, 8'h00, 8'h00));
        run_to_halt("R2 trap op 0101");
        check("R6 JC then JNC path", {23'h0, pc}, 32'd7);
        check_reg("R5 ADD low byte", 8'h20, 8'h18);
        check_reg("R4 XOR after ADD", 8'h23, 8'hC9);
        check_reg("R5 ADC with carry in", 8'h21, 8'hCA);
        check("R5 ADC clears carry", {31'h0, carry}, 32'h0);
        check_reg("R6 source-index written", 8'h02, 8'h05);
    endtask

    task automatic t_compare();
        do_reset();
        wr(8'h10, 8'h5A);
        ld(9'd0, mk(4'hE, 9'd2, 8'h10, 8'h5A));
        ld(9'd1, mk(4'h6, 9'h000, 8'h00, 8'h00));
        ld(9'd2, mk(4'hC, 9'd6, 8'h10, 8'h5A));
        ld(9'd3, mk(4'hF, 9'd5, 8'h10, 8'hA5));
        ld(9'd4, mk(4'h6, 9'h000, 8'h00, 8'h00));
        ld(9'd5, mk(4'hD, 9'd7, 8'h10, 8'h02));
        ld(9'd6, mk(4'h6, 9'h000, 8'h00, 8'h00));
        ld(9'd7, mk(4'h6, 9'h000, 8'h00, 8'h00));
        run_to_halt("R2 trap op 0110");
        check("R7 branch path", {23'h0, pc}, 32'd7);
        check_reg("R7 no source-index write", 8'h02, 8'h00);
    endtask

    task automatic t_calls();
        do_reset();
        ld(9'd0,     mk(4'hB, 9'h120, 8'h30, 8'h11));
        ld(9'd1,     mk(4'h0, 9'h040, 8'h30, 8'h77));
        ld(9'd2,     mk(4'h7, 9'h000, 8'h00, 8'h00));
        ld(9'h120,   mk(4'hB, 9'h140, 8'h02, 8'h20));
        ld(9'h121,   mk(4'h0, 9'h141, 8'h30, 8'h66));
        ld(9'h140,   mk(4'h0, 9'h142, 8'h30, 8'h55));
        run_to_halt("R2 trap after calls");
        check("R8 nested return order", {23'h0, pc}, 32'd2);
        check_reg("R8 body after outer return", 8'h40, 8'h77);
        check_reg("R8 outer routine", 8'h41, 8'h66);
        check_reg("R8 inner routine", 8'h42, 8'h55);
        check_reg("R6 call writes source-index", 8'h02, 8'h31);
    endtask

    task automatic t_debug_and_run();
        do_reset();
        ld(9'd0, {3'b001, 4'h0, 9'h060, 8'h00, 8'h44});
        run_to_halt("R2 upper bits set traps");
        check("R2 pc holds", {23'h0, pc}, 32'd0);
        check_reg("R2 no write on trap", 8'h60, 8'h00);
        run = 1'b1;
        wr(8'h61, 8'hAB);
        run = 1'b0;
        check_reg("R9 write ignored with run high", 8'h61, 8'h00);
        wr(8'h61, 8'hAB);
        check_reg("R9 write with run low", 8'h61, 8'hAB);

        do_reset();
        ld(9'd0, mk(4'h0, 9'h062, 8'h30, 8'h11));
        repeat (5) @(negedge clk);
        check("R10 pc holds with run low", {23'h0, pc}, 32'd0);
        check_reg("R10 no write with run low", 8'h62, 8'h00);
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        check("R10 one step per edge", {23'h0, pc}, 32'd1);
        check_reg("R10 step result", 8'h62, 8'h11);
        check("R10 no trap", {31'h0, illegal}, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_logic();
        t_arith_jumps();
        t_compare();
        t_calls();
        t_debug_and_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule